// File: doc/BRIEF.md
# Power-On Strap Sampler

This block serves a set of five pins that carry configuration straps while the supply comes up and clock outputs afterwards. When the supply-good signal rises, the block keeps every output buffer of those pins in high impedance for a fixed sampling window, counted in reference-clock cycles. During that time the external pull resistors alone set the pin levels. At the end of the window the synchronised pin levels are captured into a strap register and the output buffers are switched on in the same cycle.

Four of the straps select the operating frequency and the fifth is a mode strap. The mode strap decides how a separate shared pin is used once the window has closed. It either drives the reference clock or acts as an input that stops the PCI clocks. The strap register can be cleared only by removing power, which here means supply-good going low. A new rise of supply-good then runs a complete new window and captures the straps again.

Top module: `strap_sampler`

## Requirements
- R1: While `supply_good` is low, `strap_val`, `pad_oe`, `ready`, `aux_clk_oe` and `stop_in_en` are all 0. A low level clears them without waiting for a clock edge.
- R2: With `WINDOW_CYCLES` = W, `ready` is still 0 after the (W+1)th rising edge of `clk_ref` that follows the rise of `supply_good`, and it is 1 after the (W+2)th edge. This count includes two cycles of supply-good synchronisation.
- R3: Every bit of `pad_oe` is 0 for as long as `ready` is 0. All five bits go to 1 in the same cycle that `ready` rises.
- R4: `strap_val[i]` holds the level of `pad_in[i]` as it stood during the final cycles of the window. Bits 3..0 are the frequency-select straps and bit 4 is the mode strap. A level present only earlier in the window has no effect.
- R5: Once `ready` is 1, changes on `pad_in` leave `strap_val` unchanged until `supply_good` falls.
- R6: When `ready` is 1 and the mode strap `strap_val[4]` is 1, `aux_clk_oe`=1 and `stop_in_en`=0, so the shared pin drives the reference clock. When the mode strap is 0, `aux_clk_oe`=0 and `stop_in_en`=1. Both are 0 while `ready` is 0, and the two are never 1 together.
- R7: After `supply_good` falls and rises again, a full new window runs and the straps present at the end of that window replace the earlier ones.
- R8: If `supply_good` drops in the middle of a window, the count restarts from zero on the next rise. `ready` then follows the R2 timing from that rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| supply_good | input | 1 | Supply above its good threshold; low acts as power removal |
| pad_in | input | 5 | Levels read from the dual-purpose pads ([3:0] frequency select, [4] mode) |
| strap_val | output | 5 | Latched strap values |
| pad_oe | output | 5 | Per-pin output-buffer enables |
| ready | output | 1 | Window over, straps latched, clocks enabled |
| aux_clk_oe | output | 1 | Shared pin drives the reference clock |
| stop_in_en | output | 1 | Shared pin is used as the PCI stop input |

## Verification
The capture is exercised with all-zero, all-one and two alternating strap patterns. These show whether each bit lands in its own position and whether any bit is stuck or swapped. In a further run the strap levels are switched partway through the window, which shows whether the block takes the final level or an earlier one. Changing the pads after `ready` confirms that the latch stays closed. A supply drop in the middle of a window shows whether the counter restarts or resumes. Both mode values are checked to confirm the decode of the shared pin.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int NUM_STRAPS = 5;
    localparam int FSEL_BITS  = 4;
    localparam int MODE_IDX   = 4;

    typedef enum logic {
        SHARED_STOP_IN = 1'b0,
        SHARED_REF_OUT = 1'b1
    } shared_role_e;

    function automatic shared_role_e mode_to_role(input logic mode_bit);
        return mode_bit ? SHARED_REF_OUT : SHARED_STOP_IN;
    endfunction

endpackage

// File: rtl/strap_pwr_sync.sv
// Supply-good release synchroniser: asynchronous clear, synchronous release.
module strap_pwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic supply_good,
    output logic run
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge supply_good) begin
        if (!supply_good) st_q <= '0;
        else              st_q <= st_d;
    end

    assign run = st_q.sh[STAGES-1];

    // Once released, the run level holds while supply stays good (R8)
    p_run_sticky_r8: assert property (@(posedge clk) disable iff (!supply_good)
        run |=> run);
endmodule

// File: rtl/strap_window_timer.sv
// Counts the sampling window and flags its final cycle.
module strap_window_timer #(
    parameter int WINDOW_CYCLES = 28636
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic window_end,
    output logic done
);
    localparam int CNT_W = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } state_t;

    state_t st_d, st_q;
    logic   at_last;

    always_comb begin
        st_d    = st_q;
        at_last = run && !st_q.done && (st_q.cnt == LAST);
        if (run && !st_q.done) begin
            if (st_q.cnt == LAST) st_d.done = 1'b1;
            else                  st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign window_end = at_last;
    assign done       = st_q.done;

    p_cnt_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
    p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> st_q.done);
    p_no_count_before_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(st_q.cnt));
endmodule

// File: rtl/strap_capture.sv
// Per-pin synchronisers and the strap latch, loaded once per power cycle.
module strap_capture #(
    parameter int N    = 5,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pad_in,
    input  logic         capture,
    output logic [N-1:0] strap
);
    logic [N-1:0] pad_sync;

    generate
        for (genvar b = 0; b < N; b++) begin : g_bit
            logic [SYNC-1:0] ff_d, ff_q;
            always_comb ff_d = {ff_q[SYNC-2:0], pad_in[b]};
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q <= '0;
                else        ff_q <= ff_d;
            end
            assign pad_sync[b] = ff_q[SYNC-1];
        end
    endgenerate

    typedef struct packed {
        logic [N-1:0] val;
        logic         taken;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture && !st_q.taken) begin
            st_d.val   = pad_sync;
            st_d.taken = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strap = st_q.val;

    p_strap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.taken |=> $stable(st_q.val));
    p_single_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.taken |-> !capture);
endmodule

// File: rtl/strap_pin_ctrl.sv
// Output-buffer enables and the shared-pin role decode.
module strap_pin_ctrl
    import strap_pkg::*;
#(
    parameter int N    = 5,
    parameter int MIDX = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         latched,
    input  logic [N-1:0] strap,
    output logic [N-1:0] pad_oe,
    output logic         aux_clk_oe,
    output logic         stop_in_en
);
    shared_role_e role;

    always_comb begin
        role       = mode_to_role(strap[MIDX]);
        pad_oe     = {N{latched}};
        aux_clk_oe = latched && (role == SHARED_REF_OUT);
        stop_in_en = latched && (role == SHARED_STOP_IN);
    end

    p_role_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(aux_clk_oe && stop_in_en));
    p_role_needs_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_clk_oe || stop_in_en) |-> (pad_oe != '0));
endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
    import strap_pkg::*;
#(
    parameter int WINDOW_CYCLES = 28636,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                  clk_ref,
    input  logic                  supply_good,
    input  logic [NUM_STRAPS-1:0] pad_in,
    output logic [NUM_STRAPS-1:0] strap_val,
    output logic [NUM_STRAPS-1:0] pad_oe,
    output logic                  ready,
    output logic                  aux_clk_oe,
    output logic                  stop_in_en
);
    logic run;
    logic window_end;
    logic done;

    strap_pwr_sync #(.STAGES(SYNC_STAGES)) u_pwr (
        .clk         (clk_ref),
        .supply_good (supply_good),
        .run         (run)
    );

    strap_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
        .clk        (clk_ref),
        .rst_n      (supply_good),
        .run        (run),
        .window_end (window_end),
        .done       (done)
    );

    strap_capture #(.N(NUM_STRAPS), .SYNC(SYNC_STAGES)) u_cap (
        .clk     (clk_ref),
        .rst_n   (supply_good),
        .pad_in  (pad_in),
        .capture (window_end),
        .strap   (strap_val)
    );

    strap_pin_ctrl #(.N(NUM_STRAPS), .MIDX(MODE_IDX)) u_pins (
        .clk        (clk_ref),
        .rst_n      (supply_good),
        .latched    (done),
        .strap      (strap_val),
        .pad_oe     (pad_oe),
        .aux_clk_oe (aux_clk_oe),
        .stop_in_en (stop_in_en)
    );

    assign ready = done;

    p_oe_gated_r3: assert property (@(posedge clk_ref) disable iff (!supply_good)
        !ready |-> (pad_oe == '0));
    p_ready_after_end_r2: assert property (@(posedge clk_ref) disable iff (!supply_good)
        $rose(ready) |-> $past(window_end));
    p_strap_frozen_r5: assert property (@(posedge clk_ref) disable iff (!supply_good)
        (ready && $past(ready)) |-> $stable(strap_val));
endmodule

// File: tb/strap_sampler_tb.sv
module strap_sampler_tb;
    localparam int W = 64;

    logic       clk_ref = 1'b0;
    logic       supply_good = 1'b0;
    logic [4:0] pad_in = 5'b0;
    logic [4:0] strap_val, pad_oe;
    logic       ready, aux_clk_oe, stop_in_en;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk_ref = ~clk_ref;

    strap_sampler #(.WINDOW_CYCLES(W)) u_dut (
        .clk_ref     (clk_ref),
        .supply_good (supply_good),
        .pad_in      (pad_in),
        .strap_val   (strap_val),
        .pad_oe      (pad_oe),
        .ready       (ready),
        .aux_clk_oe  (aux_clk_oe),
        .stop_in_en  (stop_in_en)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic power_off();
        @(negedge clk_ref);
        supply_good = 1'b0;
        #1;
        chk("R1", "ready low", {7'b0, ready}, 8'h0);
        chk("R1", "straps cleared", {3'b0, strap_val}, 8'h0);
        chk("R1", "oe cleared", {3'b0, pad_oe}, 8'h0);
        chk("R1", "shared pin off", {6'b0, aux_clk_oe, stop_in_en}, 8'h0);
        @(negedge clk_ref);
    endtask

    // Rise supply, run window with straps s, checking R2/R3 timing.
    task automatic power_up(input logic [4:0] s, input string req);
        @(negedge clk_ref);
        pad_in      = s;
        supply_good = 1'b1;
        repeat (W + 1) @(negedge clk_ref);
        chk(req, "ready before end", {7'b0, ready}, 8'h0);
        chk("R3", "oe closed in window", {3'b0, pad_oe}, 8'h0);
        @(negedge clk_ref);
        chk(req, "ready at end", {7'b0, ready}, 8'h1);
        chk("R3", "oe open with ready", {3'b0, pad_oe}, 8'h1f);
    endtask

    task automatic t_patterns();
        logic [4:0] pats [4] = '{5'b00000, 5'b11111, 5'b10101, 5'b01010};
        foreach (pats[i]) begin
            power_up(pats[i], "R2");
            chk("R4", "latched pattern", {3'b0, strap_val}, {3'b0, pats[i]});
            chk("R6", "shared role",
                {6'b0, aux_clk_oe, stop_in_en},
                pats[i][4] ? 8'h2 : 8'h1);
            power_off();
        end
    endtask

    task automatic t_late_change();
        @(negedge clk_ref);
        pad_in      = 5'b00110;
        supply_good = 1'b1;
        repeat (W - 8) @(negedge clk_ref);
        pad_in = 5'b11001;
        repeat (12) @(negedge clk_ref);
        chk("R4", "final level wins", {3'b0, strap_val}, 8'h19);
    endtask

    task automatic t_ignore_after();
        pad_in = 5'b00110;
        repeat (5) @(negedge clk_ref);
        chk("R5", "pads ignored after latch", {3'b0, strap_val}, 8'h19);
        chk("R5", "role unchanged", {6'b0, aux_clk_oe, stop_in_en}, 8'h2);
        pad_in = 5'b01111;
        repeat (3) @(negedge clk_ref);
        chk("R5", "still frozen", {3'b0, strap_val}, 8'h19);
    endtask

    task automatic t_recycle();
        power_off();
        power_up(5'b00011, "R7");
        chk("R7", "new straps after power cycle", {3'b0, strap_val}, 8'h03);
        chk("R6", "stop input role", {6'b0, aux_clk_oe, stop_in_en}, 8'h1);
    endtask

    task automatic t_mid_drop();
        power_off();
        @(negedge clk_ref);
        pad_in      = 5'b10000;
        supply_good = 1'b1;
        repeat (W / 2) @(negedge clk_ref);
        supply_good = 1'b0;
        @(negedge clk_ref);
        power_up(5'b11100, "R8");
        chk("R8", "straps after restart", {3'b0, strap_val}, 8'h1c);
    endtask

    initial begin
        #1;
        chk("R1", "reset ready", {7'b0, ready}, 8'h0);
        chk("R1", "reset oe", {3'b0, pad_oe}, 8'h0);
        repeat (3) @(negedge clk_ref);
        chk("R1", "reset straps", {3'b0, strap_val}, 8'h0);
        t_patterns();
        t_late_change();
        t_ignore_after();
        t_recycle();
        t_mid_drop();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_ref);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule